// File: doc/BRIEF.md
# Dual-Core Package Idle-State Coordinator

This block tracks the idle (sleep) state of each core in a processor package and derives the package idle state from them. A core asks to sleep in one of two ways. It can make a direct request that carries a sub-state hint. It can also read one of a small window of power-level I/O offsets. Such a read is decoded internally into the same kind of direct request. The hint used for each offset comes from a configuration input. The read never leaves the block as a bus cycle, and it needs no monitor address to be set up first.

The package state is the deepest state that every core has reached, which is the minimum of the per-core codes. When the package moves into a state that has a power level, the block offers one notification to the chipset over a valid/ready handshake. The notification carries that level. A break event that arrives while the clock-stop input is high raises the pending-break output and returns every core, and therefore the package, to the running state.

Top module: `pkg_idle_coord`

## Requirements
- R1: While reset is low, and in the first cycle after it, every core state and the package state are 0 (running), `ntf_valid` is 0 and `pend_brk` is 0.
- R2: Per-core state codes are 0 running, 1 halt, 2 wait, 3 stop-clock, 4 sleep, 5 deep sleep, 6 deeper sleep, 7 power-down. A direct request sets that core's state to its 3-bit hint at the next clock edge.
- R3: An I/O read at offset 4+k (k = 0..4) sets that core's state at the next edge to the 3-bit hint held in `cfg_hint_map[3k+2:3k]`. A read at any other offset leaves the core state unchanged.
- R4: When a core makes a direct request and an I/O read in the same cycle, the direct request's hint wins.
- R5: `pkg_state` equals the minimum of the core state codes, one cycle after the core states change.
- R6: When the package enters a state with code 3..7, `ntf_valid` rises two cycles after the core states change. It carries `ntf_level` = code−1 (levels 2..6). Valid and level stay unchanged until `ntf_ready` is seen high at a clock edge.
- R7: Package states 0, 1 and 2 never produce a notification. A level that has been accepted is not offered again while the package stays in that level.
- R8: `brk_evt` high while `clk_stop` is high forces every core state to 0 at the next edge, overriding any request, and raises `pend_brk` at that edge.
- R9: `pend_brk` stays high while `clk_stop` stays high and clears at the first edge where `clk_stop` is low. `brk_evt` with `clk_stop` low changes neither `pend_brk` nor any core state.
- R10: After the package falls to a state below 3, re-entering a level-bearing state offers a new notification, even when it is the same level that was last accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_req_vld | input | NUM_CORES | Direct idle request, one bit per core |
| dir_req_hint | input | 3*NUM_CORES | Sub-state hint per core, core i at bits [3i+2:3i] |
| io_rd_vld | input | NUM_CORES | Power-level I/O read, one bit per core |
| io_rd_ofs | input | OFS_W*NUM_CORES | I/O read offset per core |
| cfg_hint_map | input | 3*NUM_LVL | Hint per power-level offset, offset OFS_BASE+k at bits [3k+2:3k] |
| clk_stop | input | 1 | Clock-stop request from system logic |
| brk_evt | input | 1 | Chipset break event |
| core_state | output | 3*NUM_CORES | Current state code per core |
| pkg_state | output | 3 | Package state code |
| ntf_valid | output | 1 | Power-level notification offered |
| ntf_ready | input | 1 | Chipset accepts the notification |
| ntf_level | output | LVL_W | Power level of the notification (2..6) |
| pend_brk | output | 1 | Pending-break indication |

## Verification
The bench builds the block with its default parameters. These give two cores, five offsets starting at 4, direct requests over I/O reads, and a registered package state. With these values the two-core minimum, both request paths and every offset of the power-level window can be reached in a short table. The hint map is deliberately not the identity, so a read that ignores the configuration shows up as a wrong state. Holding `ntf_ready` low while the package moves deeper tests that the payload stays stable and that a level shift is coalesced. The wake path is driven with a competing request in the same cycle.

// File: rtl/idle_pkg.sv
package idle_pkg;

   localparam int CS_W = 3;

   typedef enum logic [CS_W-1:0] {
      CS_ACTIVE  = 3'd0,
      CS_HALT    = 3'd1,
      CS_WAIT    = 3'd2,
      CS_STOPCLK = 3'd3,
      CS_SLEEP   = 3'd4,
      CS_DEEP    = 3'd5,
      CS_DEEPER  = 3'd6,
      CS_OFF     = 3'd7
   } cstate_e;

   // Power level announced for a package state; zero means none.
   function automatic logic [CS_W-1:0] level_of(input logic [CS_W-1:0] st);
      if (st >= CS_STOPCLK) return st - 3'd1;
      return '0;
   endfunction

endpackage

// File: rtl/idle_req_decode.sv
module idle_req_decode
   import idle_pkg::*;
#(
   parameter int OFS_W        = 4,
   parameter int OFS_BASE     = 4,
   parameter int NUM_LVL      = 5,
   parameter bit DIRECT_FIRST = 1'b1
) (
   input  logic                     dir_vld,
   input  logic [CS_W-1:0]          dir_hint,
   input  logic                     io_vld,
   input  logic [OFS_W-1:0]         io_ofs,
   input  logic [NUM_LVL*CS_W-1:0]  cfg_map,
   output logic                     upd,
   output cstate_e                  nxt
);

   logic    io_hit;
   cstate_e io_st;

   always_comb begin
      io_hit = 1'b0;
      io_st  = CS_ACTIVE;
      for (int k = 0; k < NUM_LVL; k++) begin
         if (io_vld && (io_ofs == OFS_W'(OFS_BASE + k))) begin
            io_hit = 1'b1;
            io_st  = cstate_e'(cfg_map[k*CS_W +: CS_W]);
         end
      end
   end

   assign upd = dir_vld | io_hit;

   generate
      if (DIRECT_FIRST) begin : g_dir_first
         assign nxt = dir_vld ? cstate_e'(dir_hint) : io_st;
      end else begin : g_io_first
         assign nxt = io_hit ? io_st : cstate_e'(dir_hint);
      end
   endgenerate

endmodule

// File: rtl/idle_core_track.sv
module idle_core_track
   import idle_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wake,
   input  logic    upd,
   input  cstate_e nxt,
   output cstate_e st
);

   always_ff @(posedge clk) begin
      if (!rst_n)    st <= CS_ACTIVE;
      else if (wake) st <= CS_ACTIVE;
      else if (upd)  st <= nxt;
   end

endmodule

// File: rtl/idle_pkg_merge.sv
module idle_pkg_merge
   import idle_pkg::*;
#(
   parameter int NUM_CORES = 2,
   parameter bit PKG_REG   = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CORES*CS_W-1:0] cores,
   output logic [CS_W-1:0]           pkg
);

   logic [CS_W-1:0] shared;

   always_comb begin
      shared = CS_OFF;
      for (int i = 0; i < NUM_CORES; i++) begin
         if (cores[i*CS_W +: CS_W] < shared) shared = cores[i*CS_W +: CS_W];
      end
   end

   generate
      if (PKG_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) pkg <= CS_ACTIVE;
            else        pkg <= shared;
         end
      end else begin : g_comb
         assign pkg = shared;
      end
   endgenerate

endmodule

// File: rtl/idle_notify.sv
module idle_notify
   import idle_pkg::*;
#(
   parameter int LVL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CS_W-1:0]   pkg,
   output logic              vld,
   input  logic              rdy,
   output logic [LVL_W-1:0]  lvl
);

   logic [LVL_W-1:0] want;
   logic [LVL_W-1:0] sent;

   assign want = LVL_W'(level_of(pkg));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         lvl  <= '0;
         sent <= '0;
      end else if (vld && rdy) begin
         vld  <= 1'b0;
         sent <= lvl;
      end else if (!vld && (want != '0) && (want != sent)) begin
         vld <= 1'b1;
         lvl <= want;
      end else if (want == '0) begin
         sent <= '0;
      end
   end

endmodule

// File: rtl/pkg_idle_coord.sv
module pkg_idle_coord
   import idle_pkg::*;
#(
   parameter int NUM_CORES    = 2,
   parameter int OFS_W        = 4,
   parameter int OFS_BASE     = 4,
   parameter int NUM_LVL      = 5,
   parameter int LVL_W        = 3,
   parameter bit DIRECT_FIRST = 1'b1,
   parameter bit PKG_REG      = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CORES-1:0]        dir_req_vld,
   input  logic [NUM_CORES*3-1:0]      dir_req_hint,
   input  logic [NUM_CORES-1:0]        io_rd_vld,
   input  logic [NUM_CORES*OFS_W-1:0]  io_rd_ofs,
   input  logic [NUM_LVL*3-1:0]        cfg_hint_map,
   input  logic                        clk_stop,
   input  logic                        brk_evt,
   output logic [NUM_CORES*3-1:0]      core_state,
   output logic [2:0]                  pkg_state,
   output logic                        ntf_valid,
   input  logic                        ntf_ready,
   output logic [LVL_W-1:0]            ntf_level,
   output logic                        pend_brk
);

   localparam int OFS_TOP = OFS_BASE + NUM_LVL - 1;

   generate
      if (NUM_CORES < 2) begin : g_bad_cores
         $error("NUM_CORES must be at least 2");
      end
      if (NUM_LVL < 1) begin : g_bad_lvl
         $error("NUM_LVL must be at least 1");
      end
      if (OFS_TOP >= (1 << OFS_W)) begin : g_bad_ofs
         $error("offset window does not fit OFS_W");
      end
      if (LVL_W < CS_W) begin : g_bad_lvlw
         $error("LVL_W too narrow for levels");
      end
   endgenerate

   logic wake;
   assign wake = clk_stop & brk_evt;

   generate
      for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
         logic    upd;
         cstate_e nxt;
         cstate_e st;

         idle_req_decode #(
            .OFS_W       (OFS_W),
            .OFS_BASE    (OFS_BASE),
            .NUM_LVL     (NUM_LVL),
            .DIRECT_FIRST(DIRECT_FIRST)
         ) u_dec (
            .dir_vld (dir_req_vld[i]),
            .dir_hint(dir_req_hint[i*3 +: 3]),
            .io_vld  (io_rd_vld[i]),
            .io_ofs  (io_rd_ofs[i*OFS_W +: OFS_W]),
            .cfg_map (cfg_hint_map),
            .upd     (upd),
            .nxt     (nxt)
         );

         idle_core_track u_trk (
            .clk  (clk),
            .rst_n(rst_n),
            .wake (wake),
            .upd  (upd),
            .nxt  (nxt),
            .st   (st)
         );

         assign core_state[i*3 +: 3] = st;
      end
   endgenerate

   idle_pkg_merge #(
      .NUM_CORES(NUM_CORES),
      .PKG_REG  (PKG_REG)
   ) u_merge (
      .clk  (clk),
      .rst_n(rst_n),
      .cores(core_state),
      .pkg  (pkg_state)
   );

   idle_notify #(
      .LVL_W(LVL_W)
   ) u_ntf (
      .clk  (clk),
      .rst_n(rst_n),
      .pkg  (pkg_state),
      .vld  (ntf_valid),
      .rdy  (ntf_ready),
      .lvl  (ntf_level)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        pend_brk <= 1'b0;
      else if (clk_stop) pend_brk <= pend_brk | brk_evt;
      else               pend_brk <= 1'b0;
   end

endmodule

// File: rtl/idle_coord_chk.sv
module idle_coord_chk #(
   parameter int NUM_CORES    = 2,
   parameter int OFS_W        = 4,
   parameter int OFS_BASE     = 4,
   parameter int NUM_LVL      = 5,
   parameter int LVL_W        = 3,
   parameter bit DIRECT_FIRST = 1'b1,
   parameter bit PKG_REG      = 1'b1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_CORES-1:0]        dir_req_vld,
   input logic [NUM_CORES*3-1:0]      dir_req_hint,
   input logic [NUM_CORES-1:0]        io_rd_vld,
   input logic [NUM_CORES*OFS_W-1:0]  io_rd_ofs,
   input logic                        clk_stop,
   input logic                        brk_evt,
   input logic [NUM_CORES*3-1:0]      core_state,
   input logic [2:0]                  pkg_state,
   input logic                        ntf_valid,
   input logic                        ntf_ready,
   input logic [LVL_W-1:0]            ntf_level,
   input logic                        pend_brk
);

   logic [2:0] low;
   always_comb begin
      low = 3'd7;
      for (int i = 0; i < NUM_CORES; i++)
         if (core_state[i*3 +: 3] < low) low = core_state[i*3 +: 3];
   end

   AST_WAKE_CORES: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_stop && brk_evt) |=> (core_state == '0)); // R8
   AST_PBE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_stop && brk_evt) |=> pend_brk); // R8
   AST_PBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_brk && clk_stop) |=> pend_brk); // R9
   AST_PBE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_stop |=> !pend_brk); // R9
   AST_NTF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ntf_valid && !ntf_ready) |=> (ntf_valid && $stable(ntf_level))); // R6
   AST_NTF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ntf_valid |-> (ntf_level >= 2 && ntf_level <= 6)); // R7

   generate
      if (PKG_REG) begin : g_pkg_reg
         AST_PKG_MIN: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (pkg_state == $past(low))); // R5
      end else begin : g_pkg_comb
         AST_PKG_MIN: assert property (@(posedge clk) disable iff (!rst_n)
            pkg_state == low); // R5
      end

      for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
         logic hit;
         assign hit = io_rd_vld[i] &&
                      (io_rd_ofs[i*OFS_W +: OFS_W] >= OFS_W'(OFS_BASE)) &&
                      (io_rd_ofs[i*OFS_W +: OFS_W] <  OFS_W'(OFS_BASE + NUM_LVL));
         if (DIRECT_FIRST) begin : g_dir
            AST_DIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
               (dir_req_vld[i] && !(clk_stop && brk_evt)) |=>
               (core_state[i*3 +: 3] == $past(dir_req_hint[i*3 +: 3]))); // R4
         end
         AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!dir_req_vld[i] && !hit && !(clk_stop && brk_evt)) |=>
            $stable(core_state[i*3 +: 3])); // R3
      end
   endgenerate

endmodule

bind pkg_idle_coord idle_coord_chk #(
   .NUM_CORES   (NUM_CORES),
   .OFS_W       (OFS_W),
   .OFS_BASE    (OFS_BASE),
   .NUM_LVL     (NUM_LVL),
   .LVL_W       (LVL_W),
   .DIRECT_FIRST(DIRECT_FIRST),
   .PKG_REG     (PKG_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dir_req_vld (dir_req_vld),
   .dir_req_hint(dir_req_hint),
   .io_rd_vld   (io_rd_vld),
   .io_rd_ofs   (io_rd_ofs),
   .clk_stop    (clk_stop),
   .brk_evt     (brk_evt),
   .core_state  (core_state),
   .pkg_state   (pkg_state),
   .ntf_valid   (ntf_valid),
   .ntf_ready   (ntf_ready),
   .ntf_level   (ntf_level),
   .pend_brk    (pend_brk)
);

// File: tb/test_pkg_idle_coord.sv
`timescale 1ns/1ps
module test_pkg_idle_coord;

   localparam int NC = 2;
   localparam int OW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] dir_req_vld = '0;
   logic [NC*3-1:0] dir_req_hint = '0;
   logic [NC-1:0] io_rd_vld = '0;
   logic [NC*OW-1:0] io_rd_ofs = '0;
   // offset 4->3, 5->5, 6->4, 7->7, 8->6
   logic [14:0]   cfg_hint_map = {3'd6, 3'd7, 3'd4, 3'd5, 3'd3};
   logic          clk_stop = 1'b0;
   logic          brk_evt = 1'b0;
   logic [NC*3-1:0] core_state;
   logic [2:0]    pkg_state;
   logic          ntf_valid;
   logic          ntf_ready = 1'b1;
   logic [2:0]    ntf_level;
   logic          pend_brk;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pkg_idle_coord i_pkg_idle_coord (
      .clk(clk), .rst_n(rst_n),
      .dir_req_vld(dir_req_vld), .dir_req_hint(dir_req_hint),
      .io_rd_vld(io_rd_vld), .io_rd_ofs(io_rd_ofs),
      .cfg_hint_map(cfg_hint_map),
      .clk_stop(clk_stop), .brk_evt(brk_evt),
      .core_state(core_state), .pkg_state(pkg_state),
      .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_level(ntf_level),
      .pend_brk(pend_brk)
   );

   // kind: 0 none, 1 direct, 2 io read
   // fields {k0[2], v0[4], k1[2], v1[4], e0[3], e1[3], epkg[3]}
   localparam logic [20:0] VEC [0:7] = '{
      {2'd1, 4'd3, 2'd0, 4'd0, 3'd3, 3'd0, 3'd0},
      {2'd0, 4'd0, 2'd1, 4'd5, 3'd3, 3'd5, 3'd3},
      {2'd2, 4'd5, 2'd2, 4'd4, 3'd5, 3'd3, 3'd3},
      {2'd2, 4'd9, 2'd2, 4'd3, 3'd5, 3'd3, 3'd3},
      {2'd2, 4'd7, 2'd1, 4'd7, 3'd7, 3'd7, 3'd7},
      {2'd2, 4'd8, 2'd2, 4'd6, 3'd6, 3'd4, 3'd4},
      {2'd1, 4'd0, 2'd0, 4'd0, 3'd0, 3'd4, 3'd0},
      {2'd1, 4'd2, 2'd1, 4'd1, 3'd2, 3'd1, 3'd1}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic set_core(input int c, input int kind, input int val);
      dir_req_vld[c]          = (kind == 1);
      dir_req_hint[c*3 +: 3]  = (kind == 1) ? val[2:0] : 3'd0;
      io_rd_vld[c]            = (kind == 2);
      io_rd_ofs[c*OW +: OW]   = (kind == 2) ? val[3:0] : 4'd0;
   endtask

   task automatic clear_req();
      dir_req_vld = '0;
      io_rd_vld   = '0;
   endtask

   task automatic both_direct(input int s);
      set_core(0, 1, s);
      set_core(1, 1, s);
      tick();
      clear_req();
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) tick();
      // R1: state held in reset
      chk("R1 core_state in reset", core_state, 0);
      chk("R1 pend_brk in reset", pend_brk, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 pkg_state after reset", pkg_state, 0);
      chk("R1 ntf_valid after reset", ntf_valid, 0);

      // table walk: R2, R3, R5
      for (int v = 0; v < 8; v++) begin
         logic [20:0] e;
         e = VEC[v];
         set_core(0, e[20:19], e[18:15]);
         set_core(1, e[14:13], e[12:9]);
         tick();
         clear_req();
         chk($sformatf("R2/R3 vector %0d core0", v), core_state[2:0], e[8:6]);
         chk($sformatf("R2/R3 vector %0d core1", v), core_state[5:3], e[5:3]);
         tick();
         chk($sformatf("R5 vector %0d pkg", v), pkg_state, e[2:0]);
      end

      // R4: direct and I/O read on core 0 in the same cycle
      dir_req_vld[0] = 1'b1; dir_req_hint[2:0] = 3'd1;
      io_rd_vld[0] = 1'b1;   io_rd_ofs[3:0] = 4'd8;
      tick();
      clear_req();
      chk("R4 direct beats io read", core_state[2:0], 1);

      // R6: held notification while ready is low
      both_direct(0);
      repeat (3) tick();
      ntf_ready = 1'b0;
      set_core(0, 1, 4); set_core(1, 1, 4);
      tick();                     // cores updated
      clear_req();
      tick();                     // package updated
      chk("R6 no valid before two cycles", ntf_valid, 0);
      tick();
      chk("R6 valid raised", ntf_valid, 1);
      chk("R6 level for sleep", ntf_level, 3);
      set_core(0, 1, 7); set_core(1, 1, 7);
      tick();
      clear_req();
      repeat (2) tick();
      chk("R6 valid held", ntf_valid, 1);
      chk("R6 level stable while held", ntf_level, 3);
      ntf_ready = 1'b1;
      tick();
      chk("R6 valid drops after accept", ntf_valid, 0);
      tick();
      chk("R6 new level offered", ntf_valid, 1);
      chk("R6 level for power-down", ntf_level, 6);
      tick();
      chk("R6 accepted", ntf_valid, 0);
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R7 no repeat of accepted level", ntf_valid, 0);
      end

      // R7: shallow package states never notify
      both_direct(2);
      for (int i = 0; i < 5; i++) begin
         tick();
         chk("R7 no notify for wait state", ntf_valid, 0);
      end

      // R10: re-entry after dropping below stop-clock
      both_direct(7);
      tick();
      tick();
      chk("R10 re-entry offered", ntf_valid, 1);
      chk("R10 re-entry level", ntf_level, 6);
      tick();

      // R9: break without clock-stop is ignored
      both_direct(3);
      tick();
      brk_evt = 1'b1;
      tick();
      brk_evt = 1'b0;
      chk("R9 no pend without clk_stop", pend_brk, 0);
      chk("R9 cores unchanged", core_state, 6'o33);

      // R8: wake overrides a request in the same cycle
      both_direct(5);
      clk_stop = 1'b1;
      tick();
      brk_evt = 1'b1;
      set_core(0, 1, 7);
      tick();
      brk_evt = 1'b0;
      clear_req();
      chk("R8 pend_brk raised", pend_brk, 1);
      chk("R8 cores running", core_state, 0);
      tick();
      chk("R8 package running", pkg_state, 0);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R9 pend_brk held", pend_brk, 1);
      end
      clk_stop = 1'b0;
      tick();
      chk("R9 pend_brk cleared", pend_brk, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule